// File: doc/BRIEF.md
# Keyed Watchdog Timer

A programmable watchdog that counts down in units of a slow timebase tick (nominally 100 ms) and raises a one-cycle timeout request to a reset sequencer when the count runs out. Software sets the period and an enable flag through a control register write. It keeps the timer from expiring by writing a fixed four-bit key to a separate restart port. A restart both reloads the counter and captures the period that the count will use from then on. Writes of any other key value do nothing.

The counter runs whether or not the request is enabled, so enabling the watchdog mid-count does not restart the period. A period code of all ones parks the counter to save power. The reset sequencer pulses a release input when it lets go of system reset, and this restarts the timer in the same way as a key write. While the supply is reported low, the watchdog is held quiet and the counter stays at its reloaded value.

Top module: `keyed_wdt`

## Requirements
- R1: After synchronous reset, timeout_req is 0, the enable flag is 0 and the captured period code is 0.
- R2: A cycle with ctrl_wr high stores ctrl_wdata bits 4:0 as the period code and ctrl_wdata bit 7 as the enable flag.
- R3: A key_wr cycle with key_wdata equal to 4'b1010 restarts the timer: the stored period code becomes the captured code and the counter is loaded with it.
- R4: A key_wr cycle with any key_wdata value other than 4'b1010 leaves the counter and the captured code unchanged.
- R5: Changing the period code through ctrl_wr does not alter the running count or the captured code until the next restart.
- R6: The counter steps down once on each tick cycle. The tick that ends a count of N ticks from a restart or from the previous expiry is an expiry. After an expiry the counter reloads from the captured code, and timeout_req is high for exactly the one cycle after the expiry edge.
- R7: With the enable flag at 0 the counter still runs, but an expiry produces no timeout_req. Setting the flag mid-count keeps the existing schedule of expiries.
- R8: A captured code of 5'b11111 stops the counter, so no expiry occurs until a restart captures another code.
- R9: A cycle with rst_release high restarts the timer exactly as a valid key write does.
- R10: While supply_low is high, timeout_req stays 0, restarts and ticks are ignored, and the counter is held at the reload value of the captured code.
- R11: A captured code of 0 gives the minimum period of one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase pulse, one per period unit |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data: bit 7 enable, bits 4:0 period code |
| key_wr | input | 1 | Restart key write strobe |
| key_wdata | input | 4 | Restart key value |
| rst_release | input | 1 | Pulse from the reset sequencer at reset release |
| supply_low | input | 1 | Supply below trip point; silences the watchdog |
| timeout_req | output | 1 | Registered one-cycle timeout request |

## Verification
The timer is run with a period of three ticks spread over idle cycles to show the periodic reload, and with a period code of zero and a tick on every cycle to tell the one-tick minimum from a count that starts at zero. A wrong key and a period change without restart are placed mid-count, where any stray reload would shift the next request. Enabling during a count separates a counter that runs while disabled from one that restarts. Long runs with the stop code, and with the supply flag held during ticks, show that the counter is frozen and then reloaded with the full period.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int PERIOD_W = 5;
  localparam int KEY_W    = 4;
  localparam int DATA_W   = 8;
  localparam int EN_BIT   = 7;
  localparam logic [KEY_W-1:0] RESTART_KEY = 4'b1010;
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs #(
  parameter int DATA_W   = 8,
  parameter int PERIOD_W = 5,
  parameter int EN_BIT   = 7,
  parameter int KEY_W    = 4,
  parameter logic [KEY_W-1:0] KEY = 4'b1010
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ctrl_wr,
  input  logic [DATA_W-1:0]   ctrl_wdata,
  input  logic                key_wr,
  input  logic [KEY_W-1:0]    key_wdata,
  input  logic                rst_release,
  output logic [PERIOD_W-1:0] period_q,
  output logic                en_q,
  output logic                restart
);
  logic key_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      en_q     <= 1'b0;
    end else if (ctrl_wr) begin
      period_q <= ctrl_wdata[PERIOD_W-1:0];
      en_q     <= ctrl_wdata[EN_BIT];
    end
  end

  always_comb begin
    key_hit = key_wr && (key_wdata == KEY);
    restart = key_hit || rst_release;
  end
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int PERIOD_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                restart,
  input  logic                hold,
  input  logic                en,
  input  logic [PERIOD_W-1:0] period_in,
  output logic [PERIOD_W-1:0] cnt_q,
  output logic [PERIOD_W-1:0] active_q,
  output logic                timeout_req
);
  localparam logic [PERIOD_W-1:0] STOP_CODE = '1;
  localparam logic [PERIOD_W-1:0] ONE       = {{(PERIOD_W-1){1'b0}}, 1'b1};

  function automatic logic [PERIOD_W-1:0] reload(input logic [PERIOD_W-1:0] code);
    return (code == '0) ? ONE : code;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= ONE;
      active_q    <= '0;
      timeout_req <= 1'b0;
    end else begin
      timeout_req <= 1'b0;
      if (hold) begin
        cnt_q <= reload(active_q);
      end else if (restart) begin
        active_q <= period_in;
        cnt_q    <= reload(period_in);
      end else if (tick && (active_q != STOP_CODE)) begin
        if (cnt_q == ONE) begin
          cnt_q       <= reload(active_q);
          timeout_req <= en;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int DATA_W   = kwdt_pkg::DATA_W,
  parameter int PERIOD_W = kwdt_pkg::PERIOD_W,
  parameter int EN_BIT   = kwdt_pkg::EN_BIT,
  parameter int KEY_W    = kwdt_pkg::KEY_W,
  parameter logic [KEY_W-1:0] KEY = kwdt_pkg::RESTART_KEY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] ctrl_wdata,
  input  logic              key_wr,
  input  logic [KEY_W-1:0]  key_wdata,
  input  logic              rst_release,
  input  logic              supply_low,
  output logic              timeout_req
);
  logic [PERIOD_W-1:0] period_q;
  logic                en_q;
  logic                restart;
  logic [PERIOD_W-1:0] cnt_q;
  logic [PERIOD_W-1:0] active_q;

  kwdt_regs #(
    .DATA_W(DATA_W), .PERIOD_W(PERIOD_W), .EN_BIT(EN_BIT),
    .KEY_W(KEY_W), .KEY(KEY)
  ) u_regs (
    .clk(clk), .rst(rst),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .key_wr(key_wr), .key_wdata(key_wdata),
    .rst_release(rst_release),
    .period_q(period_q), .en_q(en_q), .restart(restart)
  );

  kwdt_counter #(.PERIOD_W(PERIOD_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick),
    .restart(restart), .hold(supply_low), .en(en_q),
    .period_in(period_q),
    .cnt_q(cnt_q), .active_q(active_q),
    .timeout_req(timeout_req)
  );
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
  parameter int PERIOD_W = 5,
  parameter int KEY_W    = 4,
  parameter logic [KEY_W-1:0] KEY = 4'b1010
) (
  input logic                clk,
  input logic                rst,
  input logic                tick,
  input logic                key_wr,
  input logic [KEY_W-1:0]    key_wdata,
  input logic                rst_release,
  input logic                supply_low,
  input logic                timeout_req,
  input logic                en_q,
  input logic                restart,
  input logic [PERIOD_W-1:0] period_q,
  input logic [PERIOD_W-1:0] cnt_q,
  input logic [PERIOD_W-1:0] active_q
);
  localparam logic [PERIOD_W-1:0] STOP_CODE = '1;

  AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    timeout_req |-> $past(en_q)); // R7
  AST_REQ_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    timeout_req |-> $past(tick)); // R6
  AST_LOW_SILENT: assert property (@(posedge clk) disable iff (rst)
    supply_low |=> !timeout_req); // R10
  AST_RESTART_CAPTURES: assert property (@(posedge clk) disable iff (rst)
    (restart && !supply_low) |=> (active_q == $past(period_q))); // R3
  AST_STOP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (active_q == STOP_CODE && !restart && !supply_low) |=> $stable(cnt_q)); // R8
  AST_BAD_KEY_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (key_wr && key_wdata != KEY && !rst_release && !supply_low) |=> $stable(active_q)); // R4
  AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    cnt_q != '0); // R11
endmodule

bind keyed_wdt kwdt_checker #(.PERIOD_W(PERIOD_W), .KEY_W(KEY_W), .KEY(KEY)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .key_wr(key_wr), .key_wdata(key_wdata),
  .rst_release(rst_release), .supply_low(supply_low), .timeout_req(timeout_req),
  .en_q(en_q), .restart(restart), .period_q(period_q), .cnt_q(cnt_q),
  .active_q(active_q)
);

// File: tb/tb_keyed_wdt.sv
module tb_keyed_wdt;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1;
  logic       tick = 1'b0, ctrl_wr = 1'b0, key_wr = 1'b0, rst_release = 1'b0, supply_low = 1'b0;
  logic [7:0] ctrl_wdata = '0;
  logic [3:0] key_wdata = '0;
  logic       timeout_req;

  keyed_wdt dut (
    .clk(clk), .rst(rst), .tick(tick), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .key_wr(key_wr), .key_wdata(key_wdata), .rst_release(rst_release),
    .supply_low(supply_low), .timeout_req(timeout_req)
  );

  typedef struct { int due; logic exp; string tag; } item_t;
  item_t q[$];
  int cyc = 0;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // reference state built from the requirements
  logic [4:0] m_per = '0, m_act = '0, m_cnt = 5'd1;
  logic       m_en = 1'b0;

  function automatic logic [4:0] ld(input logic [4:0] c);
    return (c == 5'd0) ? 5'd1 : c;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: timeout_req=%0b expected %0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input logic tk, input logic cw, input logic [7:0] cd,
                      input logic kw, input logic [3:0] kd, input logic rel,
                      input logic low, input string tag);
    logic e;
    @(negedge clk);
    tick = tk; ctrl_wr = cw; ctrl_wdata = cd; key_wr = kw; key_wdata = kd;
    rst_release = rel; supply_low = low;
    e = 1'b0;
    if (low) m_cnt = ld(m_act);
    else if ((kw && kd == 4'b1010) || rel) begin m_act = m_per; m_cnt = ld(m_per); end
    else if (tk && m_act != 5'd31) begin
      if (m_cnt == 5'd1) begin e = m_en; m_cnt = ld(m_act); end
      else m_cnt = m_cnt - 5'd1;
    end
    if (cw) begin m_per = cd[4:0]; m_en = cd[7]; end
    q.push_back('{cyc + 1, e, tag});
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 0, 4'h0, 0, 0, tag);
  endtask
  task automatic ticks(input int n, input int gap, input string tag);
    for (int i = 0; i < n; i++) begin
      step(1, 0, 8'h00, 0, 4'h0, 0, 0, tag);
      if (gap > 0) idle(gap, tag);
    end
  endtask
  task automatic wctrl(input logic en, input logic [4:0] per, input string tag);
    step(0, 1, {en, 2'b00, per}, 0, 4'h0, 0, 0, tag);
  endtask
  task automatic wkey(input logic [3:0] k, input string tag);
    step(0, 0, 8'h00, 1, k, 0, 0, tag);
  endtask

  // monitor: pops the expected value due this cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      check(timeout_req, q[0].exp, q[0].tag);
      void'(q.pop_front());
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(timeout_req, 1'b0, "R1 reset");
    idle(2, "R1 idle");
    ticks(3, 1, "R1 disabled at reset");

    wctrl(1, 5'd3, "R2 ctrl write");
    wkey(4'b1010, "R3 key restart");
    ticks(9, 2, "R6 periodic");

    ticks(1, 1, "R4 pre");
    wkey(4'b0101, "R4 wrong key");
    wkey(4'b1011, "R4 wrong key");
    ticks(5, 1, "R4 schedule kept");

    wctrl(1, 5'd6, "R5 period change");
    ticks(7, 1, "R5 old period");
    wkey(4'b1010, "R3 new period");
    ticks(13, 0, "R3 six ticks");

    wctrl(0, 5'd4, "R7 disable");
    wkey(4'b1010, "R7 restart");
    ticks(6, 1, "R7 disabled runs");
    wctrl(1, 5'd4, "R7 enable mid");
    ticks(6, 1, "R7 schedule kept");

    wctrl(1, 5'd31, "R8 stop code");
    wkey(4'b1010, "R8 capture stop");
    ticks(40, 0, "R8 frozen");

    wctrl(1, 5'd4, "R9 period");
    ticks(2, 0, "R9 still frozen");
    step(0, 0, 8'h00, 0, 4'h0, 1, 0, "R9 release");
    ticks(9, 1, "R9 after release");

    ticks(2, 0, "R10 pre");
    for (int i = 0; i < 10; i++) step(1, 0, 8'h00, (i == 3), 4'b1010, 0, 1, "R10 low");
    ticks(9, 0, "R10 full period");

    wctrl(1, 5'd0, "R11 zero code");
    wkey(4'b1010, "R11 capture");
    ticks(5, 0, "R11 every tick");
    ticks(3, 2, "R11 spaced");
    idle(4, "R11 tail");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, cycle %0d expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule